// File: doc/BRIEF.md
# Pulse-Swallow Digital Phase-Locked Loop

A fast system clock drives a programmable divider whose wrap rate is the output clock. With no correction, the output runs at the fast clock frequency divided by the programmed ratio. That is the free-running frequency. To pull the output toward an external reference, the loop either adds one fast-clock pulse to the divider's count or swallows one. Each change moves the output phase by one fast-clock period. A bang-bang phase detector looks at where, inside the current output period, each synchronized reference rising edge lands. It then queues one correction of the right sign.

A typical setup uses a fast clock near 100 MHz and a ratio near 143, which gives about 700 kHz. Only one pulse can be added or removed per output period. For that reason the loop can follow a reference only when the reference period is within about one fast-clock cycle of the programmed ratio. Outside that range, or when there is no reference at all, the output keeps running at the divider-set rate. A lock flag reports a run of consecutive reference edges that land close to the output edge.

Top module: `pulse_steal_dpll`

## Requirements
- R1: The divider position counts 0 .. N-1 one step per fast clock, where N is the latched ratio. `clk_div_o` is high while position < N/2 (integer halving) and low otherwise. Uncorrected, an output period lasts exactly N fast clocks.
- R2: `ratio_i` (valid range 6 .. 2^W-1) is latched only on the clock where the divider wraps to position 0. A new ratio therefore takes effect from the next output period.
- R3: `ref_i` passes through two synchronizing flops and an edge flop. A rising edge reaches the phase detector on the third fast-clock edge after it is first sampled high.
- R4: At each detected reference rising edge, p is the divider position. If p = 0, the pending request is cleared. If 1 <= p < N/2, the reference is late and a delete is requested. If p >= N/2, the reference is early and an insert is requested. A newer edge replaces any request still pending.
- R5: A pending request is carried out only on the clock where the divider position equals N/2. An insert advances the position by 2, giving a period of N-1. A delete holds the position for one extra clock, giving a period of N+1. `up_o` (insert) or `dn_o` (delete) pulses high for that one clock. At most one correction happens per output period, and the two strobes are never high together.
- R6: After LOS wraps in a row with no reference edge (default 4), the loop is in loss-of-reference. Any pending request is dropped, the lock run count is cleared, and the divider free-runs with no strobes until a reference edge arrives.
- R7: `lock_o` goes high once LOCKN consecutive reference edges (default 16) land at p in {N-1, 0, 1}. An edge anywhere else restarts the run. `lock_o` stays high while the run continues.
- R8: While `rst_ni` is low, the divider position is 0, the latched ratio is RATIO_RST, no request is pending, and the lock and miss counters are zero. So `clk_div_o`=1, `lock_o`=0, `up_o`=0 and `dn_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | W | Division ratio, latched at each wrap |
| ref_i | input | 1 | Asynchronous reference input |
| clk_div_o | output | 1 | Divided output clock |
| lock_o | output | 1 | Lock indicator |
| up_o | output | 1 | One-clock strobe: a pulse was inserted |
| dn_o | output | 1 | One-clock strobe: a pulse was swallowed |

## Verification
The assertions assume that `ratio_i` never drops below 6. Below that, an insert at the half-period point could wrap the divider and the one-correction-per-period rule would not hold. The stimulus therefore uses only ratios of 143 and 100. Reference pulses are at least several fast clocks wide, so the edge detector sees clean single rises. Every reference and ratio change is driven on the falling clock edge. The reference periods are chosen both inside and outside the trackable band, and the reference is removed long enough to pass the loss-of-reference timeout.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADD  = 2'd1,
    CORR_DEL  = 2'd2
  } corr_e;
endpackage

// File: rtl/psd_ref_sync.sv
module psd_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ref_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R3
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/psd_div.sv
module psd_div import psd_pkg::*; #(
  parameter int W         = 16,
  parameter int RATIO_RST = 143
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  input  corr_e        pend_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] mid_o,
  output logic [W-1:0] ratio_o,
  output logic         wrap_o,
  output logic         apply_o,
  output logic         clk_o,
  output logic         up_o,
  output logic         dn_o
);
  logic [W-1:0] cnt_q, cnt_d, ratio_q, mid;
  logic [W:0]   sum;
  logic         hold, add;

  assign mid     = ratio_q >> 1;
  assign apply_o = (cnt_q == mid) && (pend_i != CORR_NONE);
  assign add     = apply_o && (pend_i == CORR_ADD);
  assign hold    = apply_o && (pend_i == CORR_DEL);
  assign sum     = {1'b0, cnt_q} + (add ? (W+1)'(2) : (W+1)'(1));
  assign wrap_o  = !hold && (sum >= {1'b0, ratio_q});

  always_comb begin
    if (hold)        cnt_d = cnt_q;
    else if (wrap_o) cnt_d = W'(sum - {1'b0, ratio_q});
    else             cnt_d = sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= W'(RATIO_RST);
    end else begin
      cnt_q <= cnt_d;
      if (wrap_o) ratio_q <= ratio_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign mid_o   = mid;
  assign ratio_o = ratio_q;
  assign clk_o   = cnt_q < mid;
  assign up_o    = add;
  assign dn_o    = hold;

  // checker state: a correction already taken this period
  logic corr_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     corr_seen_q <= 1'b0;
    else if (wrap_o) corr_seen_q <= 1'b0;
    else if (apply_o) corr_seen_q <= 1'b1;
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_o, dn_o}));
  // R5
  one_corr_per_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(apply_o && corr_seen_q));
  // R2
  ratio_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wrap_o) |-> $stable(ratio_q));
endmodule

// File: rtl/psd_pd.sv
module psd_pd import psd_pkg::*; #(
  parameter int W           = 16,
  parameter int LOS_PERIODS = 4,
  parameter int LOCK_CNT    = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] mid_i,
  input  logic [W-1:0] ratio_i,
  input  logic         wrap_i,
  input  logic         apply_i,
  output corr_e        pend_o,
  output logic         lock_o
);
  localparam int MW = $clog2(LOS_PERIODS + 1);
  localparam int GW = $clog2(LOCK_CNT + 1);

  logic [MW-1:0] miss_q;
  logic [GW-1:0] good_q;
  corr_e         pend_q;
  logic          los, late, early, near;

  assign los   = miss_q == MW'(LOS_PERIODS);
  assign early = cnt_i >= mid_i;
  assign late  = (cnt_i != '0) && !early;
  assign near  = (cnt_i == '0) || (cnt_i == W'(1)) || (cnt_i == ratio_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= CORR_NONE;
      miss_q <= '0;
      good_q <= '0;
    end else begin
      if (rise_i)              pend_q <= early ? CORR_ADD : (late ? CORR_DEL : CORR_NONE);
      else if (apply_i || los) pend_q <= CORR_NONE;

      if (rise_i)              miss_q <= '0;
      else if (wrap_i && !los) miss_q <= miss_q + MW'(1);

      if (rise_i) begin
        if (!near)                        good_q <= '0;
        else if (good_q != GW'(LOCK_CNT)) good_q <= good_q + GW'(1);
      end else if (los) begin
        good_q <= '0;
      end
    end
  end

  assign pend_o = pend_q;
  assign lock_o = good_q == GW'(LOCK_CNT);

  // R4
  early_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && early) |=> (pend_o == CORR_ADD));
  // R6
  los_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los && !rise_i) |=> !lock_o);
  // R7
  lock_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(rise_i));
endmodule

// File: rtl/pulse_steal_dpll.sv
module pulse_steal_dpll import psd_pkg::*; #(
  parameter int W           = 16,
  parameter int RATIO_RST   = 143,
  parameter int SYNC_STAGES = 2,
  parameter int LOS_PERIODS = 4,
  parameter int LOCK_CNT    = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  input  logic         ref_i,
  output logic         clk_div_o,
  output logic         lock_o,
  output logic         up_o,
  output logic         dn_o
);
  logic         rise, wrap, apply;
  logic [W-1:0] cnt, mid, ratio;
  corr_e        pend;

  psd_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .rise_o(rise)
  );

  psd_div #(.W(W), .RATIO_RST(RATIO_RST)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_i), .pend_i(pend),
    .cnt_o(cnt), .mid_o(mid), .ratio_o(ratio), .wrap_o(wrap),
    .apply_o(apply), .clk_o(clk_div_o), .up_o(up_o), .dn_o(dn_o)
  );

  psd_pd #(.W(W), .LOS_PERIODS(LOS_PERIODS), .LOCK_CNT(LOCK_CNT)) u_pd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .cnt_i(cnt), .mid_i(mid),
    .ratio_i(ratio), .wrap_i(wrap), .apply_i(apply), .pend_o(pend), .lock_o(lock_o)
  );
endmodule

// File: tb/pulse_steal_dpll_bench.sv
module pulse_steal_dpll_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 16;
  localparam int RST_R = 143;
  localparam int LOS   = 4;
  localparam int LOCKN = 16;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0;
  logic [W-1:0] ratio = W'(RST_R);
  logic clk_div, lock, up, dn;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_steal_dpll #(.W(W), .RATIO_RST(RST_R), .LOS_PERIODS(LOS), .LOCK_CNT(LOCKN)) u_pulse_steal_dpll (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .ref_i(ref_in),
    .clk_div_o(clk_div), .lock_o(lock), .up_o(up), .dn_o(dn)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pos, m_n, m_req, m_miss, m_run;
  bit q_sync[$];
  bit m_last;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_n = RST_R; m_req = 0; m_miss = 0; m_run = 0;
      q_sync = '{0, 0}; m_last = 0;
    end else begin
      int half, np;
      bit edge_seen, quiet, wrapped, did;
      half = m_n / 2;
      quiet = (m_miss == LOS);
      edge_seen = q_sync[1] && !m_last;
      did = (m_pos == half) && (m_req != 0);
      if (did && m_req == 2) begin
        np = m_pos; wrapped = 0;
      end else begin
        np = m_pos + ((did && m_req == 1) ? 2 : 1);
        wrapped = (np >= m_n);
        if (wrapped) np -= m_n;
      end
      if (edge_seen) begin
        if (m_pos == 0 || m_pos == 1 || m_pos == m_n - 1)
          m_run = (m_run < LOCKN) ? m_run + 1 : LOCKN;
        else
          m_run = 0;
        m_req = (m_pos >= half) ? 1 : ((m_pos == 0) ? 0 : 2);
        m_miss = 0;
      end else begin
        if (did || quiet) m_req = 0;
        if (quiet) m_run = 0;
        if (wrapped && !quiet) m_miss++;
      end
      m_last = q_sync[1];
      q_sync.pop_back();
      q_sync.push_front(ref_in);
      if (wrapped) m_n = int'(ratio);
      m_pos = np;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int half;
      half = m_n / 2;
      chk("R1 clk_div_o", int'(clk_div), int'(m_pos < half));
      chk("R3 R4 R5 up_o", int'(up), int'(m_pos == half && m_req == 1));
      chk("R3 R4 R5 dn_o", int'(dn), int'(m_pos == half && m_req == 2));
      chk("R6 R7 lock_o", int'(lock), int'(m_run == LOCKN));
    end
  end

  int n_up = 0, n_dn = 0;
  always @(negedge clk) if (rst_n) begin
    if (up) n_up++;
    if (dn) n_dn++;
  end

  task automatic drive_ref(int per, int cnt, int lead);
    repeat (lead) @(negedge clk);
    for (int i = 0; i < cnt; i++) begin
      ref_in = 1'b1;
      repeat (per / 2) @(negedge clk);
      ref_in = 1'b0;
      repeat (per - per / 2) @(negedge clk);
    end
  endtask

  task automatic measure_period(output int len);
    bit prev;
    len = 0;
    prev = clk_div;
    forever begin
      @(negedge clk);
      if (clk_div && !prev) break;
      prev = clk_div;
    end
    prev = clk_div;
    forever begin
      @(negedge clk);
      len++;
      if (clk_div && !prev) break;
      prev = clk_div;
    end
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 clk_div_o in reset", int'(clk_div), 1);
    chk("R8 lock_o in reset", int'(lock), 0);
    chk("R8 up_o/dn_o in reset", int'(up | dn), 0);
    rst_n = 1'b1;

    // R1 free run at reset ratio
    measure_period(len);
    chk("R1 free-run period", len, RST_R);

    // R2 ratio change applies at next period
    ratio = W'(100);
    repeat (2) measure_period(len);
    chk("R2 period after ratio change", len, 100);
    ratio = W'(RST_R);
    repeat (2) measure_period(len);
    chk("R2 period restored", len, RST_R);

    // R4 R7 pull-in and lock on exact-rate reference with offset
    n_up = 0; n_dn = 0;
    drive_ref(RST_R, 120, 37);
    chk("R7 lock after settled reference", int'(lock), 1);
    chk("R4 corrections used during pull-in", int'((n_up + n_dn) > 0), 1);

    // R4 R5 faster reference needs inserts
    n_up = 0;
    drive_ref(RST_R - 1, 60, 0);
    chk("R4 R5 inserts for faster reference", int'(n_up > 0), 1);

    // R4 R5 slower reference needs deletes
    n_dn = 0;
    drive_ref(RST_R + 1, 60, 0);
    chk("R4 R5 deletes for slower reference", int'(n_dn > 0), 1);

    // R6 loss of reference
    repeat (LOS + 3) measure_period(len);
    chk("R6 lock dropped after timeout", int'(lock), 0);
    n_up = 0; n_dn = 0;
    repeat (4) measure_period(len);
    chk("R6 no strobes while free-running", n_up + n_dn, 0);
    chk("R6 free-run period after loss", len, RST_R);

    // out-of-range reference: never locks
    drive_ref(RST_R + 9, 40, 0);
    chk("R7 no lock far off rate", int'(lock), 0);

    repeat (20) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule